// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit resolves conditional branches for a small processor core. A compare instruction does no arithmetic. It only copies two 32-bit register values into a pair of operand latches inside the unit. A later branch instruction supplies a 4-bit condition selector, a 10-bit displacement and its own program counter. The unit tests the latched pair against the selected relation and returns the address of the next instruction to fetch.

Ten relations are supported. They include equality, signed ordering and unsigned ordering, and each one reads as "left operand against right operand". Selector values above the ten defined ones never branch and raise an illegal-condition flag. The displacement counts halfwords, so a taken target keeps the alignment of the program counter. All results are registered. They appear on the clock edge that samples the branch strobe and then stay unchanged until the next branch.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset is active, and on the first cycle after it, `br_taken`, `bad_cond` and `next_pc` are all zero.
- R2: A cycle with `cmp_valid` high stores `cmp_a` as the left operand and `cmp_b` as the right operand. With `cmp_valid` low, the stored pair is kept for any number of cycles, whatever values `cmp_a` and `cmp_b` carry.
- R3: `br_cond` encodes the relation left-vs-right as follows: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 unsigned less-or-equal. `br_taken` reports whether the relation holds.
- R4: When the branch is taken, `next_pc` = `pc_in` + 2 + (`br_offset` sign-extended and shifted left by one), modulo 2^32.
- R5: When the branch is not taken, `next_pc` = `pc_in` + 2, whatever the offset.
- R6: For `br_cond` values 10 to 15, `br_taken` is 0, `bad_cond` is 1 and `next_pc` = `pc_in` + 2. For values 0 to 9, `bad_cond` is 0.
- R7: Outputs update on the rising edge that samples `br_valid` high, and hold their values through every cycle in which `br_valid` is low.
- R8: When `cmp_valid` and `br_valid` are high in the same cycle, the branch is judged on the operands stored before that cycle. The new pair applies from the next branch onward.
- R9: When `pc_in` is even, the resulting `next_pc` is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe: stores the operand pair |
| cmp_a | input | 32 | Left operand value |
| cmp_b | input | 32 | Right operand value |
| br_valid | input | 1 | Branch strobe: resolve a branch this cycle |
| br_cond | input | 4 | Condition selector |
| br_offset | input | 10 | Signed halfword displacement |
| pc_in | input | 32 | Address of the branch instruction |
| br_taken | output | 1 | Last branch was taken |
| next_pc | output | 32 | Address to fetch after the last branch |
| bad_cond | output | 1 | Last branch used an undefined selector |

## Verification
A compare and a branch can arrive in the same cycle, and the branch must not see the operands arriving with it. The bench stores an unequal pair first. It then raises both strobes together, with an equal pair on the compare inputs and an equality branch on the branch inputs, and expects the branch to be not taken. A second equality branch that follows on its own must then be taken, which shows the new pair was stored after the first branch was judged.

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  parameter int OFF_W    = 10,
  parameter int COND_W   = 4,
  parameter int NUM_COND = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              br_valid,
  input  logic [COND_W-1:0] br_cond,
  input  logic [OFF_W-1:0]  br_offset,
  input  logic [PC_W-1:0]   pc_in,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc,
  output logic              bad_cond
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [DATA_W-1:0] lhs_q, rhs_q;
  logic              eq, lt_s, lt_u, hit, legal;
  logic [PC_W-1:0]   disp, seq_pc, jmp_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lhs_q <= '0;
      rhs_q <= '0;
    end else if (cmp_valid) begin
      lhs_q <= cmp_a;
      rhs_q <= cmp_b;
    end
  end

  assign eq    = (lhs_q == rhs_q);
  assign lt_s  = ($signed(lhs_q) < $signed(rhs_q));
  assign lt_u  = (lhs_q < rhs_q);
  assign legal = (32'(br_cond) < NUM_COND);

  always_comb begin
    case (br_cond)
      COND_W'(0): hit = eq;
      COND_W'(1): hit = !eq;
      COND_W'(2): hit = lt_s;
      COND_W'(3): hit = !lt_s && !eq;
      COND_W'(4): hit = lt_u;
      COND_W'(5): hit = !lt_u && !eq;
      COND_W'(6): hit = !lt_s;
      COND_W'(7): hit = lt_s || eq;
      COND_W'(8): hit = !lt_u;
      COND_W'(9): hit = lt_u || eq;
      default:    hit = 1'b0;
    endcase
  end

  assign disp   = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, 1'b0};
  assign seq_pc = pc_in + STEP;
  assign jmp_pc = seq_pc + disp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_taken <= 1'b0;
      bad_cond <= 1'b0;
      next_pc  <= '0;
    end else if (br_valid) begin
      br_taken <= hit && legal;
      bad_cond <= !legal;
      next_pc  <= (hit && legal) ? jmp_pc : seq_pc;
    end
  end
endmodule

// File: rtl/cmp_branch_unit_sva.sv
module cmp_branch_unit_sva #(
  parameter int PC_W   = 32,
  parameter int COND_W = 4,
  parameter int NUM_COND = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [COND_W-1:0] br_cond,
  input logic [PC_W-1:0]   pc_in,
  input logic              br_taken,
  input logic [PC_W-1:0]   next_pc,
  input logic              bad_cond
);
  AST_BAD_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cond |-> !br_taken); // R6

  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && 32'(br_cond) >= NUM_COND) |=> (bad_cond && next_pc == $past(pc_in) + PC_W'(2))); // R6

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (br_taken || next_pc == $past(pc_in) + PC_W'(2))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> ($stable(next_pc) && $stable(br_taken) && $stable(bad_cond))); // R7

  AST_EVEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !pc_in[0]) |=> !next_pc[0]); // R9
endmodule

bind cmp_branch_unit cmp_branch_unit_sva #(
  .PC_W(PC_W), .COND_W(COND_W), .NUM_COND(NUM_COND)
) u_sva (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
  .pc_in(pc_in), .br_taken(br_taken), .next_pc(next_pc), .bad_cond(bad_cond)
);

// File: tb/cmp_branch_unit_tb.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [9:0]  br_offset = '0;
  logic [31:0] pc_in = '0;
  logic        br_taken, bad_cond;
  logic [31:0] next_pc;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cmp_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_cond(br_cond), .br_offset(br_offset), .pc_in(pc_in),
    .br_taken(br_taken), .next_pc(next_pc), .bad_cond(bad_cond)
  );

  // {a, b, cond, offset, pc, exp_taken, exp_bad}
  localparam int NV = 13;
  localparam logic [111:0] VEC [NV] = '{
    {32'h0000_0005, 32'h0000_0005, 4'd0,  10'h001, 32'h0000_0100, 1'b1, 1'b0},
    {32'h0000_0005, 32'h0000_0006, 4'd1,  10'h3FF, 32'h0000_0200, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'd2,  10'h200, 32'h0000_1000, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'd4,  10'h055, 32'h0000_0300, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'd5,  10'h1FF, 32'h0000_0400, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'd3,  10'h010, 32'h0000_0500, 1'b0, 1'b0},
    {32'h0000_0007, 32'h0000_0007, 4'd6,  10'h001, 32'hFFFF_FFFE, 1'b1, 1'b0},
    {32'h0000_0007, 32'h0000_0007, 4'd7,  10'h3F0, 32'h0000_0010, 1'b1, 1'b0},
    {32'h0000_0003, 32'h0000_0008, 4'd8,  10'h004, 32'h0000_0600, 1'b0, 1'b0},
    {32'h8000_0000, 32'h7FFF_FFFF, 4'd9,  10'h004, 32'h0000_0700, 1'b0, 1'b0},
    {32'h8000_0000, 32'h7FFF_FFFF, 4'd2,  10'h004, 32'h0000_0800, 1'b1, 1'b0},
    {32'h0000_0001, 32'h0000_0001, 4'd10, 10'h020, 32'h0000_0900, 1'b0, 1'b1},
    {32'h0000_0001, 32'h0000_0001, 4'd15, 10'h020, 32'h0000_0A00, 1'b0, 1'b1}
  };

  function automatic logic [31:0] ref_pc(logic [31:0] pc, logic [9:0] off, logic tk);
    logic [31:0] d;
    d = {{21{off[9]}}, off, 1'b0};
    return tk ? pc + 32'd2 + d : pc + 32'd2;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmp(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic do_br(logic [3:0] c, logic [9:0] off, logic [31:0] pc);
    @(negedge clk);
    br_valid = 1'b1; br_cond = c; br_offset = off; pc_in = pc;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 taken in reset", 32'(br_taken), 32'd0);
    chk("R1 bad in reset", 32'(bad_cond), 32'd0);
    chk("R1 pc in reset", next_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", next_pc, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [111:0] v;
      v = VEC[i];
      do_cmp(v[111:80], v[79:48]);
      do_br(v[47:44], v[43:34], v[33:2]);
      chk($sformatf("R3 taken vec%0d", i), 32'(br_taken), 32'(v[1]));
      chk($sformatf("R6 bad vec%0d", i), 32'(bad_cond), 32'(v[0]));
      chk($sformatf("R4 R5 pc vec%0d", i), next_pc, ref_pc(v[33:2], v[43:34], v[1]));
      chk($sformatf("R9 even vec%0d", i), 32'(next_pc[0]), 32'd0);
    end

    // R7: outputs hold while br_valid is low
    do_cmp(32'd2, 32'd9);
    do_br(4'd4, 10'h008, 32'h0000_2000);
    chk("R7 update", next_pc, 32'h0000_2012);
    @(negedge clk);
    br_cond = 4'd0; br_offset = 10'h100; pc_in = 32'h0000_5000;
    repeat (3) @(negedge clk);
    chk("R7 hold pc", next_pc, 32'h0000_2012);
    chk("R7 hold taken", 32'(br_taken), 32'd1);

    // R2: operands persist; cmp inputs ignored without strobe
    do_cmp(32'd9, 32'd9);
    @(negedge clk);
    cmp_a = 32'd1; cmp_b = 32'd100;
    repeat (5) @(negedge clk);
    do_br(4'd0, 10'h002, 32'h0000_3000);
    chk("R2 persist taken", 32'(br_taken), 32'd1);
    chk("R2 persist pc", next_pc, 32'h0000_3006);

    // R8: compare and branch in the same cycle
    do_cmp(32'd1, 32'd2);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = 32'd4; cmp_b = 32'd4;
    br_valid = 1'b1; br_cond = 4'd0; br_offset = 10'h040; pc_in = 32'h0000_4000;
    @(negedge clk);
    cmp_valid = 1'b0; br_valid = 1'b0;
    chk("R8 old operands", 32'(br_taken), 32'd0);
    chk("R8 old pc", next_pc, 32'h0000_4002);
    do_br(4'd0, 10'h040, 32'h0000_4000);
    chk("R8 new operands", 32'(br_taken), 32'd1);
    chk("R8 new pc", next_pc, 32'h0000_4082);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule